// File: doc/BRIEF.md
# Register-File Arithmetic/Logic Datapath

This block is the arithmetic core of a small processor. It holds sixteen 8-bit unsigned general registers. Each command names a left source register, a right source register and a destination register. The two sources are chosen independently, so one register may feed both operands and may also receive the result.

The add, subtract, AND and divide circuits all evaluate the selected operands at the same time. A result multiplexer, steered by the command's operation code, picks which value is written back to the destination. A compare command writes no register. It updates three condition flags, exactly one of which is set afterwards, and the flags keep their value until the next compare. A load command copies an immediate byte from the command port into a register, so a typical sequence is: load two registers, run an operation, and read the third register. Any register can be observed through a read port.

Commands arrive on a valid/ready port. Back-pressure rules:
- `cmd_ready` is low while reset is asserted and high at all other times.
- A command takes effect on a rising clock edge only when both `cmd_valid` and `cmd_ready` are high.
- A source that holds `cmd_valid` high while `cmd_ready` is low keeps its command until the handshake completes.
- The register write and the flag update of an accepted command land on the same edge that accepts it.

Top module: `rfalu_core`

## Requirements
- R1: Operation code 1 (load) writes `cmd_imm` into register `cmd_dst`. From the cycle after acceptance, `rd_data` shows the new value whenever `rd_sel` equals `cmd_dst`.
- R2: The left operand comes from register `cmd_lsel` and the right operand from register `cmd_rsel`, chosen independently. The same register may serve as both sources and as the destination, and reads return the values held before the write.
- R3: Operation codes 2, 3 and 4 write left+right, left−right and left AND right into `cmd_dst`. The add and subtract results are taken modulo 256.
- R4: Operation code 5 writes floor(left / right) into `cmd_dst` when right is non-zero.
- R5: Operation code 6 (compare) sets exactly one flag: `cond_gt` when left > right, `cond_eq` when left = right, `cond_lt` when left < right. It writes no register.
- R6: The condition flags are all zero after reset. They change only on an accepted compare.
- R7: Divide with a zero right operand writes 0xFF into `cmd_dst` and sets `div_err`. `div_err` stays set until reset.
- R8: A command without the handshake has no effect. Operation codes 0 and 7 are accepted but change no register, no flag and no error state. `cmd_ready` is low during reset and high otherwise.
- R9: Reset clears all sixteen registers to zero and clears `div_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Operation code (0 none, 1 load, 2 add, 3 sub, 4 and, 5 div, 6 compare, 7 none) |
| cmd_dst | input | 4 | Destination register index |
| cmd_lsel | input | 4 | Left operand register index |
| cmd_rsel | input | 4 | Right operand register index |
| cmd_imm | input | 8 | Immediate byte for load |
| rd_sel | input | 4 | Register index for observation |
| rd_data | output | 8 | Contents of register `rd_sel` |
| cond_gt | output | 1 | Last compare: left greater |
| cond_eq | output | 1 | Last compare: equal |
| cond_lt | output | 1 | Last compare: left smaller |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions check several properties on every cycle:
- At most one condition flag is set at any time.
- The flags do not move unless a compare is accepted.
- The error flag never clears outside reset.
- Every write lands in the addressed register.
- The divider's quotient and remainder obey the division identity for every operand pair it sees, and the quotient is all ones when the divisor is zero.

Some behaviour only the bench scenarios can show:
- Wrap-around values of add and subtract.
- Correct operand routing when one register is used as both sources and the destination.
- No write by compare or by the unused codes.
- Commands held back without `cmd_valid` leaving state untouched.
- Each value read back through the observation port after a sequence of loads and operations.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_AND  = 3'd4,
    OP_DIV  = 3'd5,
    OP_CMP  = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  function automatic logic op_writes(input op_e op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
           (op == OP_AND)  || (op == OP_DIV);
  endfunction
endpackage

// File: rtl/rfalu_regfile.sv
module rfalu_regfile #(
  parameter int DATA_W = 8,
  parameter int REG_N  = 16,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  ra_sel,
  output logic [DATA_W-1:0] ra_data,
  input  logic [SEL_W-1:0]  rb_sel,
  output logic [DATA_W-1:0] rb_data,
  input  logic [SEL_W-1:0]  rc_sel,
  output logic [DATA_W-1:0] rc_data,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] mem [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && (waddr == SEL_W'(g)))
        mem[g] <= wdata;
    end
  end

  assign ra_data = mem[ra_sel];
  assign rb_data = mem[rb_sel];
  assign rc_data = mem[rc_sel];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata))); // R1
endmodule

// File: rtl/rfalu_divider.sv
module rfalu_divider #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] num,
  input  logic [DATA_W-1:0] den,
  output logic [DATA_W-1:0] quo,
  output logic [DATA_W-1:0] rem
);
  logic [DATA_W:0] part [DATA_W+1];

  assign part[0] = '0;

  for (genvar k = 0; k < DATA_W; k++) begin : g_stage
    logic [DATA_W:0] shifted;
    logic            fits;
    assign shifted = {part[k][DATA_W-1:0], num[DATA_W-1-k]};
    assign fits    = shifted >= {1'b0, den};
    assign quo[DATA_W-1-k] = fits;
    assign part[k+1] = fits ? (shifted - {1'b0, den}) : shifted;
  end

  assign rem = part[DATA_W][DATA_W-1:0];
endmodule

// File: rtl/rfalu_ops.sv
module rfalu_ops
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] div_quo,
  output logic [DATA_W-1:0] div_rem,
  output logic              div_zero,
  output logic              lt,
  output logic              eq,
  output logic              gt
);
  logic [DATA_W-1:0] sum_v, diff_v, and_v;

  assign sum_v  = lhs + rhs;
  assign diff_v = lhs - rhs;
  assign and_v  = lhs & rhs;

  rfalu_divider #(.DATA_W(DATA_W)) u_div (
    .num(lhs), .den(rhs), .quo(div_quo), .rem(div_rem)
  );

  assign div_zero = (rhs == '0);
  assign eq = (lhs == rhs);
  assign lt = (lhs < rhs);
  assign gt = !eq && !lt;

  always_comb begin
    unique case (op)
      OP_LOAD: result = imm;
      OP_ADD:  result = sum_v;
      OP_SUB:  result = diff_v;
      OP_AND:  result = and_v;
      OP_DIV:  result = div_quo;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/rfalu_core.sv
module rfalu_core
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_N  = 16,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [SEL_W-1:0]  cmd_dst,
  input  logic [SEL_W-1:0]  cmd_lsel,
  input  logic [SEL_W-1:0]  cmd_rsel,
  input  logic [DATA_W-1:0] cmd_imm,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              cond_gt,
  output logic              cond_eq,
  output logic              cond_lt,
  output logic              div_err
);
  op_e               op;
  logic              accept;
  logic [DATA_W-1:0] lhs, rhs, result, quo, rem;
  logic              dz, c_lt, c_eq, c_gt;
  logic [2:0]        cond_q;
  logic              err_q;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = rst_n;
  assign accept    = cmd_valid && cmd_ready;

  rfalu_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_sel(cmd_lsel), .ra_data(lhs),
    .rb_sel(cmd_rsel), .rb_data(rhs),
    .rc_sel(rd_sel),   .rc_data(rd_data),
    .we(accept && op_writes(op)), .waddr(cmd_dst), .wdata(result)
  );

  rfalu_ops #(.DATA_W(DATA_W)) u_ops (
    .op(op), .lhs(lhs), .rhs(rhs), .imm(cmd_imm),
    .result(result), .div_quo(quo), .div_rem(rem), .div_zero(dz),
    .lt(c_lt), .eq(c_eq), .gt(c_gt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      if (op == OP_CMP)
        cond_q <= {c_gt, c_eq, c_lt};
      if (op == OP_DIV && dz)
        err_q <= 1'b1;
    end
  end

  assign {cond_gt, cond_eq, cond_lt} = cond_q;
  assign div_err = err_q;

  AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cond_gt, cond_eq, cond_lt})); // R5
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && op == OP_CMP) |=> $stable({cond_gt, cond_eq, cond_lt})); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err); // R7
  AST_DIV_ZERO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    dz |-> (quo == '1)); // R7
  AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    !dz |-> ((rem < rhs) &&
             ((2*DATA_W)'(quo) * (2*DATA_W)'(rhs) + (2*DATA_W)'(rem)
              == (2*DATA_W)'(lhs)))); // R4
endmodule

// File: tb/rfalu_core_bench.sv
module rfalu_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [3:0] cmd_dst, cmd_lsel, cmd_rsel, rd_sel;
  logic [7:0] cmd_imm, rd_data;
  logic       cond_gt, cond_eq, cond_lt, div_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfalu_core u_rfalu_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_lsel(cmd_lsel), .cmd_rsel(cmd_rsel),
    .cmd_imm(cmd_imm), .rd_sel(rd_sel), .rd_data(rd_data),
    .cond_gt(cond_gt), .cond_eq(cond_eq), .cond_lt(cond_lt), .div_err(div_err)
  );

  typedef struct {
    logic [3:0] sel;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         vectors = 0;
  int         miscompares = 0;
  bit         finished = 0;
  logic [7:0] model [16];
  logic [2:0] exp_cond = '0;
  logic       exp_err = 1'b0;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(bit valid, logic [2:0] op, logic [3:0] dst,
                       logic [3:0] l, logic [3:0] r, logic [7:0] imm, string tag);
    logic [7:0] a, b;
    a = model[l];
    b = model[r];
    @(negedge clk);
    cmd_valid = valid;
    cmd_op    = op;
    cmd_dst   = dst;
    cmd_lsel  = l;
    cmd_rsel  = r;
    cmd_imm   = imm;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    if (valid) begin
      case (op)
        3'd1: model[dst] = imm;
        3'd2: model[dst] = a + b;
        3'd3: model[dst] = a - b;
        3'd4: model[dst] = a & b;
        3'd5: begin
          model[dst] = (b == 0) ? 8'hFF : a / b;
          if (b == 0) exp_err = 1'b1;
        end
        3'd6: exp_cond = {a > b, a == b, a < b};
        default: ;
      endcase
    end
    sb.push_back('{dst, model[dst], tag});
    check({tag, " cond"}, {cond_gt, cond_eq, cond_lt}, exp_cond);
    check({tag, " err"}, div_err, exp_err);
  endtask

  // Monitor: pops expected register contents and compares at the read port
  initial begin
    item_t it;
    forever begin
      wait (sb.size() > 0);
      it = sb.pop_front();
      rd_sel = it.sel;
      #1;
      check(it.tag, rd_data, it.val);
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = '0; cmd_dst = '0; cmd_lsel = '0; cmd_rsel = '0; cmd_imm = '0;
    rd_sel = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 ready in reset", cmd_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 ready after reset", cmd_ready, 1);
    check("R6 cond reset", {cond_gt, cond_eq, cond_lt}, 0);
    check("R9 err reset", div_err, 0);
    for (int i = 0; i < 16; i++) sb.push_back('{4'(i), 8'h00, "R9 reg reset"});
    wait (sb.size() == 0);

    issue(1, 3'd1, 4'd0, 4'd0, 4'd0, 8'd200, "R1 load");
    issue(1, 3'd1, 4'd1, 4'd0, 4'd0, 8'd100, "R1 load");
    issue(1, 3'd1, 4'd15, 4'd0, 4'd0, 8'd7, "R1 load top");
    issue(1, 3'd2, 4'd2, 4'd0, 4'd1, 8'd0, "R3 add wrap");
    issue(1, 3'd3, 4'd3, 4'd1, 4'd0, 8'd0, "R3 sub wrap");
    issue(1, 3'd4, 4'd4, 4'd0, 4'd1, 8'd0, "R3 and");
    issue(1, 3'd5, 4'd5, 4'd0, 4'd15, 8'd0, "R4 div");
    issue(1, 3'd5, 4'd6, 4'd15, 4'd0, 8'd0, "R4 div small");
    issue(1, 3'd2, 4'd1, 4'd1, 4'd1, 8'd0, "R2 same reg");
    issue(1, 3'd6, 4'd0, 4'd0, 4'd15, 8'd0, "R5 cmp gt");
    issue(1, 3'd2, 4'd7, 4'd15, 4'd15, 8'd0, "R6 hold after add");
    issue(1, 3'd6, 4'd15, 4'd15, 4'd0, 8'd0, "R5 cmp lt");
    issue(1, 3'd6, 4'd3, 4'd5, 4'd5, 8'd0, "R5 cmp eq");
    issue(0, 3'd1, 4'd0, 4'd0, 4'd0, 8'd55, "R8 no valid");
    issue(1, 3'd0, 4'd0, 4'd0, 4'd0, 8'd55, "R8 op none");
    issue(1, 3'd7, 4'd2, 4'd0, 4'd1, 8'd55, "R8 op rsvd");
    issue(1, 3'd5, 4'd8, 4'd0, 4'd9, 8'd0, "R7 div zero");
    issue(1, 3'd5, 4'd9, 4'd0, 4'd15, 8'd0, "R7 err sticky");
    issue(1, 3'd5, 4'd10, 4'd9, 4'd9, 8'd0, "R4 div self");
    issue(1, 3'd6, 4'd11, 4'd0, 4'd0, 8'd0, "R5 cmp self");

    wait (sb.size() == 0);
    #(CLK_PERIOD);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule